// File: doc/BRIEF.md
# Window Watchdog Pulse-Width Checker

This block supervises a microcontroller through a single trigger line that the software toggles at a steady rate. Every stretch between two consecutive level changes counts as one pulse, whether the line sat high or low. Each pulse width is measured in cycles of a slow reference clock and judged against a lower and an upper bound.

A pulse at or below the lower bound is a fault. So is a line that stays put until the upper bound is reached, which covers both a late edge and a trigger that has stopped altogether. A fault raises the failure flag. The flag drops only after a fixed run of back-to-back in-window pulses, and any bad pulse during that run starts the count over.

An enable input models the standby state. While it is low, the pulse timer and the recovery count are held at zero and the flag keeps its value. The trigger passes through a synchronizer before its edges are detected. The first edge after reset or after the enable returns only starts timing, because no interval before it can be measured.

Top module: `wdt_window_chk`

## Requirements
- R1: While reset is applied and after it is released, `fail_o` is 0 and `nofail_o` is 1 until a fault is judged.
- R2: A pulse of width W reference cycles with LO_CYC < W < HI_CYC is in-window and leaves a clear flag clear.
- R3: A judged pulse with W <= LO_CYC sets `fail_o`.
- R4: If no edge arrives for HI_CYC cycles after the last edge, or after enable, `fail_o` is set without waiting for an edge. A pulse with W >= HI_CYC is therefore a fault.
- R5: Low phases are measured and judged exactly like high phases.
- R6: With `fail_o` set, it clears on the GOOD_RUN-th consecutive in-window pulse and not earlier.
- R7: A faulty pulse during recovery sets the run count back to zero, so GOOD_RUN fresh in-window pulses are needed.
- R8: While `enable` is 0, the timer and the run count are held at zero, trigger edges are ignored, no timeout fires, and `fail_o` holds its value. A partial recovery run is discarded.
- R9: `nofail_o` is always the inverse of `fail_o`.
- R10: A trigger change that ends a pulse updates the flags on the third rising clock edge after the change is presented.
- R11: The first edge after reset release or after `enable` rises is not judged. It only starts the timing of the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the pulse timer |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Monitoring enable; low means standby |
| trig_in | input | 1 | Asynchronous trigger line from the microcontroller |
| fail_o | output | 1 | Failure flag |
| nofail_o | output | 1 | Inverse of the failure flag |

## Verification
The bench builds the block with LO_CYC=6, HI_CYC=14 and GOOD_RUN=4, so each width boundary can be hit on both sides in a few cycles: 6 against 7, and 13 against 14. A full recovery run, a run broken by a bad pulse, and a run split across standby all fit in a short vector table. The small upper bound also lets the timeout be timed to the exact cycle, and a standby period much longer than that bound shows that no timeout fires while the block is disabled.

// File: rtl/wdt_window_pkg.sv
// Shared types for the window watchdog checker.
// Assumes: none; purely declarative.
package wdt_window_pkg;

    // Outcome reported for the current cycle by the pulse timer.
    typedef enum logic [1:0] {
        PW_NONE = 2'd0,   // nothing judged this cycle
        PW_GOOD = 2'd1,   // a pulse ended strictly inside the window
        PW_BAD  = 2'd2    // short pulse, long pulse or timeout
    } pw_verdict_t;

endpackage

// File: rtl/wdt_trig_sync.sv
// Trigger synchronizer and edge detector.
// Brings the asynchronous trigger into the clock domain through SYNC_STAGES
// flops and flags any level change of the synchronized signal for one cycle.
// Assumes: SYNC_STAGES >= 2.
module wdt_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic lvl_o,
    output logic edge_o
);

    logic [SYNC_STAGES-1:0] chain;
    logic                   lvl_d;

    // First synchronizer stage samples the raw line.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= trig_in;
    end

    // Remaining stages, one flop each.
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    // Delayed copy of the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= chain[SYNC_STAGES-1];
    end

    assign lvl_o  = chain[SYNC_STAGES-1];
    assign edge_o = chain[SYNC_STAGES-1] ^ lvl_d;

endmodule

// File: rtl/wdt_pulse_timer.sv
// Pulse-width timer and window classifier.
// Counts reference cycles since the last edge. The count saturates at HI_CYC.
// It judges each ending pulse against the window and reports a timeout when
// HI_CYC cycles pass without an edge. The first edge after reset or enable
// only arms the judge.
// Assumes: LO_CYC + 1 < HI_CYC; edge_i is a one-cycle pulse per level change.
module wdt_pulse_timer
    import wdt_window_pkg::*;
#(
    parameter int LO_CYC = 26,
    parameter int HI_CYC = 89,
    parameter int CNT_W  = $clog2(HI_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             edge_i,
    output pw_verdict_t      verdict_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             armed_o
);

    localparam logic [CNT_W-1:0] LO_V  = CNT_W'(LO_CYC);
    localparam logic [CNT_W-1:0] HI_V  = CNT_W'(HI_CYC);
    localparam logic [CNT_W-1:0] TO_V  = CNT_W'(HI_CYC - 1);
    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic             armed;

    // Width counter: restarts at one on an edge, saturates at the upper bound.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (edge_i) begin
            cnt   <= ONE_V;
            armed <= 1'b1;
        end else if (cnt != HI_V) begin
            cnt   <= cnt + ONE_V;
        end
    end

    // Classify the pulse that ends now, or flag a timeout.
    always_comb begin
        verdict_o = PW_NONE;
        if (enable) begin
            if (edge_i) begin
                if (armed) begin
                    if (cnt <= LO_V || cnt >= HI_V) verdict_o = PW_BAD;
                    else                            verdict_o = PW_GOOD;
                end
            end else if (cnt == TO_V) begin
                verdict_o = PW_BAD;
            end
        end
    end

    assign cnt_o   = cnt;
    assign armed_o = armed;

endmodule

// File: rtl/wdt_fault_latch.sv
// Failure flag with recovery run counter.
// Any bad verdict sets the flag and clears the run. While the flag is set,
// each good verdict advances the run, and the GOOD_RUN-th consecutive one
// clears the flag. Standby clears the run and holds the flag.
// Assumes: GOOD_RUN >= 1.
module wdt_fault_latch
    import wdt_window_pkg::*;
#(
    parameter int GOOD_RUN = 16,
    parameter int RUN_W    = $clog2(GOOD_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  pw_verdict_t      verdict_i,
    output logic             fail_o,
    output logic [RUN_W-1:0] run_cnt_o
);

    localparam logic [RUN_W-1:0] LAST_V = RUN_W'(GOOD_RUN - 1);
    localparam logic [RUN_W-1:0] ONE_V  = RUN_W'(1);

    logic             fail_q;
    logic [RUN_W-1:0] run_q;

    // Update flag and recovery run from the current verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
            run_q  <= '0;
        end else if (!enable) begin
            run_q  <= '0;
        end else begin
            case (verdict_i)
                PW_BAD: begin
                    fail_q <= 1'b1;
                    run_q  <= '0;
                end
                PW_GOOD: begin
                    if (fail_q) begin
                        if (run_q == LAST_V) begin
                            fail_q <= 1'b0;
                            run_q  <= '0;
                        end else begin
                            run_q  <= run_q + ONE_V;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign fail_o    = fail_q;
    assign run_cnt_o = run_q;

endmodule

// File: rtl/wdt_window_chk.sv
// Window watchdog pulse-width checker, top level.
// Synchronizes the trigger, times every high and low phase, and keeps a
// failure flag that needs GOOD_RUN consecutive in-window pulses to clear.
// Assumes: clk is the slow reference clock; bounds are given in its cycles.
module wdt_window_chk #(
    parameter int LO_CYC      = 26,
    parameter int HI_CYC      = 89,
    parameter int GOOD_RUN    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trig_in,
    output logic fail_o,
    output logic nofail_o
);

    import wdt_window_pkg::*;

    localparam int CNT_W = $clog2(HI_CYC + 1);
    localparam int RUN_W = $clog2(GOOD_RUN + 1);

    logic             trig_lvl;
    logic             trig_edge;
    pw_verdict_t      verdict;
    logic [CNT_W-1:0] pw_cnt;
    logic             pw_armed;
    logic [RUN_W-1:0] run_cnt;
    logic             fail_q;

    wdt_trig_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .lvl_o   (trig_lvl),
        .edge_o  (trig_edge)
    );

    wdt_pulse_timer #(
        .LO_CYC (LO_CYC),
        .HI_CYC (HI_CYC),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .edge_i    (trig_edge),
        .verdict_o (verdict),
        .cnt_o     (pw_cnt),
        .armed_o   (pw_armed)
    );

    wdt_fault_latch #(
        .GOOD_RUN (GOOD_RUN),
        .RUN_W    (RUN_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .verdict_i (verdict),
        .fail_o    (fail_q),
        .run_cnt_o (run_cnt)
    );

    assign fail_o   = fail_q;
    assign nofail_o = ~fail_q;

endmodule

// File: rtl/wdt_window_chk_sva.sv
// Assertion checker for the window watchdog, bound to the top module.
// Assumes: attached through the bind statement at the end of this file.
module wdt_window_chk_sva #(
    parameter int LO_CYC   = 26,
    parameter int HI_CYC   = 89,
    parameter int GOOD_RUN = 16,
    parameter int CNT_W    = $clog2(HI_CYC + 1),
    parameter int RUN_W    = $clog2(GOOD_RUN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             fail_o,
    input logic             trig_edge,
    input logic [CNT_W-1:0] pw_cnt,
    input logic             pw_armed,
    input logic [RUN_W-1:0] run_cnt
);

    // R4
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pw_cnt <= CNT_W'(HI_CYC));

    // R4
    timeout_sets_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !trig_edge && pw_cnt == CNT_W'(HI_CYC - 1)) |=> fail_o);

    // R3
    short_sets_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && trig_edge && pw_armed && pw_cnt <= CNT_W'(LO_CYC)) |=> fail_o);

    // R2
    good_keeps_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && trig_edge && pw_armed && !fail_o &&
         pw_cnt > CNT_W'(LO_CYC) && pw_cnt < CNT_W'(HI_CYC)) |=> !fail_o);

    // R6
    clear_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail_o) |-> ($past(run_cnt) == RUN_W'(GOOD_RUN - 1) &&
                           $past(trig_edge) && $past(pw_armed)));

    // R8
    standby_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pw_cnt == '0 && run_cnt == '0 && !pw_armed));

    // R8
    standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable)) |-> $stable(fail_o));

endmodule

bind wdt_window_chk wdt_window_chk_sva #(
    .LO_CYC   (LO_CYC),
    .HI_CYC   (HI_CYC),
    .GOOD_RUN (GOOD_RUN)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .fail_o    (fail_o),
    .trig_edge (trig_edge),
    .pw_cnt    (pw_cnt),
    .pw_armed  (pw_armed),
    .run_cnt   (run_cnt)
);

// File: tb/wdt_window_chk_tb.sv
module wdt_window_chk_tb;

    localparam int LO = 6;
    localparam int HI = 14;
    localparam int GR = 4;
    localparam int NV = 22;

    // Pulse width in cycles, expected flag after that pulse is judged, tag.
    localparam int    VW [NV] = '{10, 8, 13, 7, 6, 10, 10, 10, 10, 5, 9,
                                  9, 4, 9, 9, 9, 9, 14, 9, 9, 9, 9};
    localparam bit    VF [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 0, 1, 1,
                                  1, 1, 1, 1, 1, 0, 1, 1, 1, 1, 0};
    localparam string VT [NV] = '{"R2", "R2", "R2", "R2", "R3", "R6", "R6", "R6",
                                  "R6", "R5", "R7", "R7", "R7", "R7", "R7", "R7",
                                  "R7", "R4", "R4", "R6", "R6", "R6"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic trig_in = 1'b0;
    logic fail_o;
    logic nofail_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    wdt_window_chk #(
        .LO_CYC   (LO),
        .HI_CYC   (HI),
        .GOOD_RUN (GR),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .trig_in  (trig_in),
        .fail_o   (fail_o),
        .nofail_o (nofail_o)
    );

    task automatic check(input string tag, input bit exp);
        n_chk++;
        if (fail_o !== exp) begin
            n_bad++;
            $display("FAIL %s fail_o=%b expected=%b t=%0t", tag, fail_o, exp, $time);
        end
        n_chk++;
        if (nofail_o !== ~exp) begin
            n_bad++;
            $display("FAIL R9 nofail_o=%b expected=%b t=%0t", nofail_o, ~exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle();
        trig_in = ~trig_in;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_n(4);
        check("R1", 1'b0);
        rst_n = 1'b1;
        wait_n(1);
        check("R1", 1'b0);

        // Vector table: each toggle ends the previous pulse.
        for (int i = 0; i < NV; i++) begin
            toggle();
            wait_n(3);
            if (i == 0) check("R11", 1'b0);
            else        check(VT[i-1], VF[i-1]);
            wait_n(VW[i] - 3);
        end
        toggle();
        wait_n(3);
        check(VT[NV-1], VF[NV-1]);

        // R4: exact timeout cycle with the trigger stalled.
        wait_n(HI - 2);
        check("R4", 1'b0);
        wait_n(1);
        check("R4", 1'b1);

        // R6: recover with GR good pulses after the long one.
        for (int k = 0; k < GR; k++) begin
            toggle();
            wait_n(9);
        end
        toggle();
        wait_n(3);
        check("R6", 1'b0);

        // R10: a short pulse of width LO; flag moves on the third edge.
        wait_n(3);
        toggle();
        wait_n(2);
        check("R10", 1'b0);
        wait_n(1);
        check("R10", 1'b1);

        // R8: partial run discarded by standby.
        wait_n(6);
        toggle();
        wait_n(9);
        toggle();
        wait_n(3);
        check("R8", 1'b1);
        enable = 1'b0;
        wait_n(20);
        toggle();
        wait_n(2);
        toggle();
        wait_n(20);
        check("R8", 1'b1);
        enable = 1'b1;
        wait_n(2);
        toggle();
        wait_n(9);
        for (int k = 1; k <= GR; k++) begin
            toggle();
            wait_n(3);
            check("R8", (k == GR) ? 1'b0 : 1'b1);
            wait_n(6);
        end

        // R8: no timeout in standby; R11: first edge after enable not judged.
        enable = 1'b0;
        wait_n(40);
        check("R8", 1'b0);
        enable = 1'b1;
        wait_n(2);
        toggle();
        wait_n(3);
        check("R11", 1'b0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule